// File: doc/BRIEF.md
# Voltage Regulator Mode Sequencer

This block is the digital control core of a multiphase buck regulator controller. It reads the enable pin, a deep-sleep request, a power-state hint, a 7-bit VID code and a few analog comparator flags. From these it selects one of five operating modes: shutdown, boot, full power, phase-shed and single-phase sleep. From the selected mode it drives the phase enables, the phase tristate and force-low controls, the pulse-skip and slew-rate selects, the external driver skip line, the threshold blanking flag and the DAC target selector.

Startup is sequenced. After the enable pin rises, the block waits for the reference-ready comparator. It then enters a boot ramp at a quarter of the nominal slew rate and leaves that ramp once the output sits inside its regulation window. The active-low clock-enable and the power-good outputs then assert in turn, power-good after a programmable delay. The all-ones VID code acts as a soft shutdown, and leaving it repeats the whole boot path. The VID code passes through a stability filter, so skewed bit changes never reach the target.

Top module: `vr_mode_seq`

## Requirements
- R1: While `en_i` is sampled low, the next cycle shows the shutdown mode: every phase disabled, every `drv_lo_o` bit high, the external phases tristated, `tgt_sel_o`=0 (zero target), `clken_n_o` high and `pgood_o` low. The other control inputs have no effect.
- R2: With `en_i` high and an accepted VID that is not the OFF code, the sequencer waits in shutdown mode until `ref_ok_i` is sampled high. It then enters boot: all NPH phases enabled, `pskip_o`=1, `slew_q_o`=1 (quarter slew) and `tgt_sel_o`=1 (boot target).
- R3: Boot ends, and the run state begins with `tgt_sel_o`=2 (VID target), at the first edge where `uv_ok_i` and `ov_ok_i` are both high.
- R4: In the run state with `dslp_i`=0 and `pstate_i`=1, all NPH phases run in forced-PWM mode at nominal slew, with `dskip_o`=1 and no tristate.
- R5: In the run state with `dslp_i`=0 and `pstate_i`=0, the last phase is dropped in the same cycle as the pin change: `phase_cnt_o`=NPH-1, the top bit of `ph_tri_o` is high and `dskip_o`=0.
- R6: In the run state with `dslp_i`=1, the block selects one phase in pulse-skip mode whatever `pstate_i` is. The integrated driver of phase index 1 is forced low, the external phases are tristated, and `dskip_o`=0.
- R7: Once the all-ones VID (127) is accepted, the sequencer goes to shutdown mode at the next edge. When a different VID is accepted, the sequencer re-runs the reference wait and the boot.
- R8: A VID value becomes `tgt_vid_o` only after `vid_i` has held it for STAB+1 consecutive edges. `vid_chg_o` pulses for exactly the cycle in which the accepted value changes. After reset `tgt_vid_o` is 127.
- R9: `clken_n_o` falls one edge after the run state and the regulation window are both true. `pgood_o` rises PG_DLY edges after that. Both return to inactive at the first edge where that condition is false.
- R10: In sleep mode `blank_o`=1 and `ov_ok_i` is ignored by the regulation window. Outside sleep mode, `ov_ok_i` low breaks the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable pin, low = shutdown |
| dslp_i | input | 1 | Deep-sleep request |
| pstate_i | input | 1 | Power-state hint, low = shed one phase |
| vid_i | input | 7 | Raw VID code |
| ref_ok_i | input | 1 | Reference above its ready threshold |
| uv_ok_i | input | 1 | Output above lower regulation threshold |
| ov_ok_i | input | 1 | Output below upper regulation threshold |
| phase_cnt_o | output | 2 | Number of active phases |
| pskip_o | output | 1 | 1 = pulse skipping, 0 = forced PWM |
| slew_q_o | output | 1 | 1 = quarter slew rate |
| ph_en_o | output | NPH | Per-phase enable |
| ph_tri_o | output | NPH | Tristate for external-driver phases |
| drv_lo_o | output | NDRV | Force-low of integrated drivers |
| dskip_o | output | 1 | External driver forced-PWM line |
| clken_n_o | output | 1 | Clock enable, active low |
| pgood_o | output | 1 | Power good |
| blank_o | output | 1 | Upper threshold blanking |
| tgt_sel_o | output | 2 | Target: 0 zero, 1 boot, 2 VID |
| tgt_vid_o | output | 7 | Accepted VID code |
| vid_chg_o | output | 1 | One-cycle pulse on accepted VID change |

## Verification
The hardest state to reach is a VID code that is rejected because its bits arrive skewed. The stimulus holds one code for fewer edges than the filter needs and then moves on to another code, so the bench can observe that the first code never reaches the target. The next hardest is the OFF code taken during full regulation. The stimulus reaches it from a settled run state with power-good high. It then leaves the OFF code and follows the sequencer back through the reference wait and the boot while the reference flag stays high. Sleep-mode blanking is reached by dropping the upper window flag only after sleep is active. The flag stays low as sleep ends, so power-good holds through sleep and falls when sleep ends.

// File: rtl/vrms_pkg.sv
package vrms_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WREF = 2'd1,
        ST_BOOT = 2'd2,
        ST_RUN  = 2'd3
    } seq_st_e;

    typedef enum logic [2:0] {
        MD_SHDN  = 3'd0,
        MD_BOOT  = 3'd1,
        MD_FULL  = 3'd2,
        MD_SHED  = 3'd3,
        MD_SLEEP = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        TGT_ZERO = 2'd0,
        TGT_BOOT = 2'd1,
        TGT_VID  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic pskip;
        logic slew_q;
        logic dskip;
        logic blank;
        tgt_e tgt;
    } mode_ctl_t;

    function automatic mode_e pick_mode(seq_st_e st, logic dslp, logic pst);
        mode_e m;
        case (st)
            ST_BOOT: m = MD_BOOT;
            ST_RUN:  m = dslp ? MD_SLEEP : (pst ? MD_FULL : MD_SHED);
            default: m = MD_SHDN;
        endcase
        return m;
    endfunction

    function automatic mode_ctl_t mode_ctl(mode_e m);
        mode_ctl_t c;
        c.pskip  = (m == MD_BOOT) || (m == MD_SLEEP);
        c.slew_q = (m == MD_BOOT);
        c.dskip  = (m == MD_FULL);
        c.blank  = (m == MD_SLEEP);
        case (m)
            MD_SHDN: c.tgt = TGT_ZERO;
            MD_BOOT: c.tgt = TGT_BOOT;
            default: c.tgt = TGT_VID;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/vrms_vid_filt.sv
module vrms_vid_filt #(
    parameter int VID_W = 7,
    parameter int STAB  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VID_W-1:0] vid_i,
    output logic [VID_W-1:0] vid_q_o,
    output logic             chg_o
);
    localparam int CW = (STAB < 1) ? 1 : $clog2(STAB + 1);

    logic [VID_W-1:0] cand_q;
    logic [CW-1:0]    cnt_q;
    logic             settled;

    assign settled = (cnt_q == CW'(STAB));

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q  <= '1;
            cnt_q   <= '0;
            vid_q_o <= '1;
            chg_o   <= 1'b0;
        end else begin
            chg_o <= 1'b0;
            if (settled && (cand_q != vid_q_o)) begin
                vid_q_o <= cand_q;
                chg_o   <= 1'b1;
            end
            if (vid_i != cand_q) begin
                cand_q <= vid_i;
                cnt_q  <= '0;
            end else if (!settled) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vrms_seq_fsm.sv
module vrms_seq_fsm
    import vrms_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en_i,
    input  logic    off_i,
    input  logic    ref_ok_i,
    input  logic    win_ok_i,
    output seq_st_e st_o
);
    seq_st_e st_n;

    always_comb begin
        st_n = st_o;
        if (!en_i || off_i) begin
            st_n = ST_OFF;
        end else begin
            case (st_o)
                ST_OFF:  st_n = ST_WREF;
                ST_WREF: if (ref_ok_i) st_n = ST_BOOT;
                ST_BOOT: if (win_ok_i) st_n = ST_RUN;
                default: st_n = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_o <= ST_OFF;
        else     st_o <= st_n;
    end
endmodule

// File: rtl/vrms_phase_dec.sv
module vrms_phase_dec
    import vrms_pkg::*;
#(
    parameter int NPH  = 3,
    parameter int NDRV = 2
) (
    input  mode_e                      mode_i,
    output logic [$clog2(NPH+1)-1:0]   phase_cnt_o,
    output logic [NPH-1:0]             ph_en_o,
    output logic [NPH-1:0]             ph_tri_o,
    output logic [NDRV-1:0]            drv_lo_o
);
    localparam int PC_W = $clog2(NPH + 1);

    always_comb begin
        case (mode_i)
            MD_BOOT, MD_FULL: phase_cnt_o = PC_W'(NPH);
            MD_SHED:          phase_cnt_o = PC_W'(NPH - 1);
            MD_SLEEP:         phase_cnt_o = PC_W'(1);
            default:          phase_cnt_o = '0;
        endcase
    end

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        assign ph_en_o[i] = (PC_W'(i) < phase_cnt_o);
        if (i < NDRV) begin : g_int
            assign drv_lo_o[i] = !ph_en_o[i];
            assign ph_tri_o[i] = 1'b0;
        end else begin : g_ext
            assign ph_tri_o[i] = !ph_en_o[i];
        end
    end
endmodule

// File: rtl/vrms_pg_timer.sv
module vrms_pg_timer #(
    parameter int PG_DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ok_i,
    output logic clken_n_o,
    output logic pgood_o
);
    localparam int TW = (PG_DLY < 1) ? 1 : $clog2(PG_DLY + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !ok_i) begin
            cnt_q     <= '0;
            clken_n_o <= 1'b1;
            pgood_o   <= 1'b0;
        end else begin
            clken_n_o <= 1'b0;
            if (cnt_q == TW'(PG_DLY)) pgood_o <= 1'b1;
            else                      cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/vr_mode_seq.sv
module vr_mode_seq
    import vrms_pkg::*;
#(
    parameter int NPH    = 3,
    parameter int NDRV   = 2,
    parameter int VID_W  = 7,
    parameter int STAB   = 3,
    parameter int PG_DLY = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en_i,
    input  logic                      dslp_i,
    input  logic                      pstate_i,
    input  logic [VID_W-1:0]          vid_i,
    input  logic                      ref_ok_i,
    input  logic                      uv_ok_i,
    input  logic                      ov_ok_i,
    output logic [$clog2(NPH+1)-1:0]  phase_cnt_o,
    output logic                      pskip_o,
    output logic                      slew_q_o,
    output logic [NPH-1:0]            ph_en_o,
    output logic [NPH-1:0]            ph_tri_o,
    output logic [NDRV-1:0]           drv_lo_o,
    output logic                      dskip_o,
    output logic                      clken_n_o,
    output logic                      pgood_o,
    output logic                      blank_o,
    output logic [1:0]                tgt_sel_o,
    output logic [VID_W-1:0]          tgt_vid_o,
    output logic                      vid_chg_o
);
    seq_st_e   st;
    mode_e     mode;
    mode_ctl_t ctl;
    logic      off_code;
    logic      win_ok;
    logic      run_ok;

    vrms_vid_filt #(.VID_W(VID_W), .STAB(STAB)) filt_i (
        .clk(clk), .rst(rst), .vid_i(vid_i),
        .vid_q_o(tgt_vid_o), .chg_o(vid_chg_o)
    );

    assign off_code = &tgt_vid_o;
    assign mode     = pick_mode(st, dslp_i, pstate_i);
    assign ctl      = mode_ctl(mode);
    assign win_ok   = uv_ok_i && (ov_ok_i || ctl.blank);
    assign run_ok   = (st == ST_RUN) && win_ok;

    vrms_seq_fsm fsm_i (
        .clk(clk), .rst(rst), .en_i(en_i), .off_i(off_code),
        .ref_ok_i(ref_ok_i), .win_ok_i(win_ok), .st_o(st)
    );

    vrms_phase_dec #(.NPH(NPH), .NDRV(NDRV)) dec_i (
        .mode_i(mode), .phase_cnt_o(phase_cnt_o), .ph_en_o(ph_en_o),
        .ph_tri_o(ph_tri_o), .drv_lo_o(drv_lo_o)
    );

    vrms_pg_timer #(.PG_DLY(PG_DLY)) pg_i (
        .clk(clk), .rst(rst), .ok_i(run_ok),
        .clken_n_o(clken_n_o), .pgood_o(pgood_o)
    );

    assign pskip_o   = ctl.pskip;
    assign slew_q_o  = ctl.slew_q;
    assign dskip_o   = ctl.dskip;
    assign blank_o   = ctl.blank;
    assign tgt_sel_o = ctl.tgt;
endmodule

// File: rtl/vrms_chk.sv
module vrms_chk #(
    parameter int NPH   = 3,
    parameter int NDRV  = 2,
    parameter int VID_W = 7
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     en_i,
    input logic [VID_W-1:0]         vid_i,
    input logic [$clog2(NPH+1)-1:0] phase_cnt_o,
    input logic [NPH-1:0]           ph_en_o,
    input logic [NPH-1:0]           ph_tri_o,
    input logic [NDRV-1:0]          drv_lo_o,
    input logic                     clken_n_o,
    input logic                     pgood_o,
    input logic [1:0]               tgt_sel_o,
    input logic [VID_W-1:0]         tgt_vid_o,
    input logic                     vid_chg_o
);
    a_r1_shdn_off: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (ph_en_o == '0 && drv_lo_o == '1 && tgt_sel_o == 2'd0));

    a_r7_off_zero: assert property (@(posedge clk) disable iff (rst)
        (tgt_vid_o == '1) |=> (tgt_sel_o == 2'd0));

    a_r8_chg_moves: assert property (@(posedge clk) disable iff (rst)
        vid_chg_o |-> !$stable(tgt_vid_o));

    a_r8_stable_src: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgt_vid_o) |-> ($past(vid_i, 2) == tgt_vid_o));

    a_r9_pg_needs_clken: assert property (@(posedge clk) disable iff (rst)
        pgood_o |-> !clken_n_o);

    a_r9_pg_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(pgood_o) |-> $past(!clken_n_o));

    a_r6_one_phase: assert property (@(posedge clk) disable iff (rst)
        (phase_cnt_o == 1) |-> (ph_tri_o[NPH-1] && !drv_lo_o[0]));
endmodule

bind vr_mode_seq vrms_chk #(.NPH(NPH), .NDRV(NDRV), .VID_W(VID_W)) chk_i (
    .clk(clk), .rst(rst), .en_i(en_i), .vid_i(vid_i),
    .phase_cnt_o(phase_cnt_o), .ph_en_o(ph_en_o), .ph_tri_o(ph_tri_o),
    .drv_lo_o(drv_lo_o), .clken_n_o(clken_n_o), .pgood_o(pgood_o),
    .tgt_sel_o(tgt_sel_o), .tgt_vid_o(tgt_vid_o), .vid_chg_o(vid_chg_o)
);

// File: tb/vr_mode_seq_tb.sv
module vr_mode_seq_tb_top;
    localparam int CLK_P  = 10;
    localparam int NPH    = 3;
    localparam int NDRV   = 2;
    localparam int STAB   = 3;
    localparam int PG_DLY = 4;

    logic clk = 1'b0;
    logic rst, en, dslp, pstate, ref_ok, uv_ok, ov_ok;
    logic [6:0] vid;
    logic [1:0] phase_cnt;
    logic pskip, slew_q, dskip, clken_n, pgood, blank, vid_chg;
    logic [NPH-1:0] ph_en, ph_tri;
    logic [NDRV-1:0] drv_lo;
    logic [1:0] tgt_sel;
    logic [6:0] tgt_vid;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    vr_mode_seq #(.NPH(NPH), .NDRV(NDRV), .VID_W(7), .STAB(STAB), .PG_DLY(PG_DLY)) dut_i (
        .clk(clk), .rst(rst), .en_i(en), .dslp_i(dslp), .pstate_i(pstate),
        .vid_i(vid), .ref_ok_i(ref_ok), .uv_ok_i(uv_ok), .ov_ok_i(ov_ok),
        .phase_cnt_o(phase_cnt), .pskip_o(pskip), .slew_q_o(slew_q),
        .ph_en_o(ph_en), .ph_tri_o(ph_tri), .drv_lo_o(drv_lo), .dskip_o(dskip),
        .clken_n_o(clken_n), .pgood_o(pgood), .blank_o(blank),
        .tgt_sel_o(tgt_sel), .tgt_vid_o(tgt_vid), .vid_chg_o(vid_chg)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: 0 off, 1 wait-ref, 2 boot, 3 run
    int m_st, m_cand, m_cnt, m_vidq, m_chg, m_clkn, m_pgc, m_pg;

    always @(posedge clk) begin
        int o_cand, o_cnt, ns;
        bit off, win, okrun;
        if (rst) begin
            m_st = 0; m_cand = 127; m_cnt = 0; m_vidq = 127; m_chg = 0;
            m_clkn = 1; m_pgc = 0; m_pg = 0;
        end else begin
            off   = (m_vidq == 127);
            win   = uv_ok && (ov_ok || (m_st == 3 && dslp));
            okrun = (m_st == 3) && win;
            if (!en || off) ns = 0;
            else if (m_st == 0) ns = 1;
            else if (m_st == 1) ns = ref_ok ? 2 : 1;
            else if (m_st == 2) ns = win ? 3 : 2;
            else ns = 3;
            if (!okrun) begin
                m_clkn = 1; m_pgc = 0; m_pg = 0;
            end else begin
                m_clkn = 0;
                if (m_pgc == PG_DLY) m_pg = 1; else m_pgc++;
            end
            o_cand = m_cand; o_cnt = m_cnt;
            m_chg = (o_cnt == STAB && o_cand != m_vidq);
            if (m_chg != 0) m_vidq = o_cand;
            if (int'(vid) != o_cand) begin
                m_cand = int'(vid); m_cnt = 0;
            end else if (o_cnt < STAB) m_cnt++;
            m_st = ns;
        end
    end

    always @(negedge clk) begin
        int md, pc, e_en;
        string tg;
        if (!rst) begin
            if (m_st < 2) md = 0;
            else if (m_st == 2) md = 1;
            else if (dslp) md = 4;
            else if (pstate) md = 2;
            else md = 3;
            case (md)
                0: begin pc = 0; tg = "R1"; end
                1: begin pc = 3; tg = "R2"; end
                2: begin pc = 3; tg = "R4"; end
                3: begin pc = 2; tg = "R5"; end
                default: begin pc = 1; tg = "R6"; end
            endcase
            e_en = (1 << pc) - 1;
            chk(tg, "phase_cnt", int'(phase_cnt), pc);
            chk(tg, "ph_en", int'(ph_en), e_en);
            chk(tg, "ph_tri", int'(ph_tri), ((e_en & 4) != 0) ? 0 : 4);
            chk(tg, "drv_lo", int'(drv_lo), (~e_en) & 3);
            chk(tg, "pskip", int'(pskip), (md == 1 || md == 4) ? 1 : 0);
            chk(tg, "slew_q", int'(slew_q), (md == 1) ? 1 : 0);
            chk(tg, "dskip", int'(dskip), (md == 2) ? 1 : 0);
            chk(tg, "tgt_sel", int'(tgt_sel), (md == 0) ? 0 : ((md == 1) ? 1 : 2));
            chk("R10", "blank", int'(blank), (md == 4) ? 1 : 0);
            chk("R9", "clken_n", int'(clken_n), m_clkn);
            chk("R9", "pgood", int'(pgood), m_pg);
            chk("R8", "tgt_vid", int'(tgt_vid), m_vidq);
            chk("R8", "vid_chg", int'(vid_chg), m_chg);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic at_neg();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1; en = 0; dslp = 0; pstate = 0; ref_ok = 0; uv_ok = 0; ov_ok = 0;
        vid = 7'h20;
        step(3);
        at_neg();
        chk("R1", "reset pgood", int'(pgood), 0);
        chk("R1", "reset clken_n", int'(clken_n), 1);
        chk("R8", "reset tgt_vid", int'(tgt_vid), 127);
        chk("R1", "reset tgt_sel", int'(tgt_sel), 0);
        step(0);
        rst = 0;
        // R1: shutdown ignores the other inputs
        for (int k = 0; k < 6; k++) begin
            dslp = k[0]; pstate = k[1]; ref_ok = 1; uv_ok = 1; ov_ok = 1;
            step(1);
        end
        at_neg();
        chk("R1", "ph_en while disabled", int'(ph_en), 0);
        chk("R1", "pgood while disabled", int'(pgood), 0);
        // R2: reference wait then boot
        dslp = 0; pstate = 1; ref_ok = 0; uv_ok = 0; ov_ok = 0;
        step(1);
        en = 1;
        step(5);
        chk("R2", "tgt_sel waiting ref", int'(tgt_sel), 0);
        ref_ok = 1;
        step(1);
        chk("R2", "slew_q in boot", int'(slew_q), 1);
        chk("R2", "phase_cnt in boot", int'(phase_cnt), NPH);
        // R3: needs both window flags
        step(3);
        uv_ok = 1;
        step(2);
        chk("R3", "tgt_sel boot until window", int'(tgt_sel), 1);
        ov_ok = 1;
        step(1);
        chk("R3", "tgt_sel after boot", int'(tgt_sel), 2);
        step(8);
        chk("R9", "pgood after delay", int'(pgood), 1);
        // R5: immediate shed
        pstate = 0;
        #1;
        chk("R5", "ph_tri top on shed", int'(ph_tri[NPH-1]), 1);
        chk("R5", "dskip on shed", int'(dskip), 0);
        step(3);
        // R6: sleep regardless of pstate
        dslp = 1;
        #1;
        chk("R6", "phase_cnt sleep", int'(phase_cnt), 1);
        pstate = 1;
        step(2);
        chk("R6", "phase_cnt sleep pstate high", int'(phase_cnt), 1);
        // R10: blanking of the upper window flag
        ov_ok = 0;
        step(4);
        chk("R10", "pgood held while blanked", int'(pgood), 1);
        dslp = 0;
        step(2);
        chk("R10", "pgood lost without blanking", int'(pgood), 0);
        ov_ok = 1;
        step(8);
        // R8: skewed code rejected, stable code accepted
        vid = 7'h21;
        step(2);
        vid = 7'h25;
        step(1);
        chk("R8", "tgt_vid before settle", int'(tgt_vid), 32'h20);
        step(6);
        chk("R8", "tgt_vid after settle", int'(tgt_vid), 32'h25);
        // R7: OFF code and exit
        vid = 7'h7F;
        step(6);
        chk("R7", "tgt_sel on off code", int'(tgt_sel), 0);
        step(2);
        chk("R7", "pgood on off code", int'(pgood), 0);
        vid = 7'h30;
        step(16);
        chk("R7", "tgt_sel after reboot", int'(tgt_sel), 2);
        chk("R7", "pgood after reboot", int'(pgood), 1);
        // R1: shutdown from run
        en = 0;
        step(1);
        chk("R1", "ph_en after disable", int'(ph_en), 0);
        step(2);
        chk("R1", "pgood after disable", int'(pgood), 0);
        step(2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule